// File: doc/BRIEF.md
# Hardware Cursor Overlay Mixer

This block sits in a display pixel path and lays a 32 by 32 cursor image over a raster stream of frame pixels. Each incoming pixel carries its column and row. When the pixel falls inside the cursor rectangle, the block replaces or modifies it using the cursor word stored for that position. Every other pixel passes through untouched. The result leaves the block two clock cycles after it enters.

A cursor slot can hold one of two kinds of image. In a monochrome mask cursor, every position carries an AND bit and an XOR bit, and these act on the frame pixel. In an alpha cursor, every position carries a 32-bit colour word whose top byte weights the cursor colour against the frame pixel. Images are loaded into an internal RAM through a define port, one word per write.

Placement is controlled through a small register file. The slot, column and row values are staged first. They take effect together only when a code is written to the visibility register.

Top module: `cursor_overlay_mixer`

## Requirements
- R1: After reset, outValid and outData are 0 and the cursor is hidden, so that later pixels pass through unchanged.
- R2: Register writes use regAddr 0 for the slot id, 1 for the column and 2 for the row (low 12 bits of regWrData). These writes only stage values and do not change the output until the visibility register is written.
- R3: A write of code 1 (show) to regAddr 3 commits the staged slot, column and row and makes the cursor visible. A write of code 0 (hide) commits them and hides the cursor, so that every pixel passes unchanged.
- R4: Codes 2 (remove from frame memory) and 3 (restore to frame memory) written to regAddr 3 change no state. Any value above 3 is ignored as well.
- R5: In a monochrome slot, bit 0 of the word is the AND bit and bit 1 is the XOR bit. Each covered output equals (pixel AND {24{andBit}}) XOR {24{xorBit}}.
- R6: In an alpha slot, the word is laid out as alpha[31:24], R[23:16], G[15:8], B[7:0], the same colour layout as the pixels. Each output channel equals floor((a*cur + (255-a)*pix)/255).
- R7: A define write stores defWord at word address row*32+col of slot defSlot. It also sets that slot's kind from defAlpha. A define write with defAlpha=1 while capAlpha=0 is ignored, and leaves both the word and the slot kind unchanged.
- R8: The cursor covers columns X..X+31 and rows Y..Y+31, computed without wrap-around. Pixels at or beyond the active width (640) or height (480) pass unchanged even when the cursor covers them.
- R9: outValid equals pixValid delayed by two cycles. outData holds its previous value while outValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| capAlpha | input | 1 | Alpha cursors permitted |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 id, 1 column, 2 row, 3 visibility |
| regWrData | input | 16 | Register write data |
| defWe | input | 1 | Cursor image word write strobe |
| defAlpha | input | 1 | Word belongs to an alpha cursor |
| defSlot | input | 1 | Slot being defined |
| defAddr | input | 10 | Word address, row*32+col |
| defWord | input | 32 | Cursor image word |
| pixValid | input | 1 | Input pixel valid |
| pixX | input | 12 | Input pixel column |
| pixY | input | 12 | Input pixel row |
| pixData | input | 24 | Input pixel RGB |
| outValid | output | 1 | Output pixel valid |
| outData | output | 24 | Output pixel RGB |

## Verification
The assertions take for granted that the visibility register is written only with regWrEn and regAddr 3. They also assume that pixel coordinates are stable while pixValid is high, and that pixValid is held low during reset. The bench drives every input on the falling edge and keeps pixValid at 0 while rstN is low. It writes both slots completely before any visible pixel is sent, so no covered pixel ever reads an undefined word. Only codes 0 to 3 and one out-of-range code are written to the visibility register.

// File: rtl/cursor_mix_pkg.sv
package cursor_mix_pkg;
  localparam int COORD_W = 12;
  localparam int PIX_W   = 24;
  localparam int WORD_W  = 32;

  typedef enum logic [1:0] {
    SEL_ID = 2'd0,
    SEL_X  = 2'd1,
    SEL_Y  = 2'd2,
    SEL_ON = 2'd3
  } regSel_e;

  typedef enum logic [1:0] {
    ON_HIDE    = 2'd0,
    ON_SHOW    = 2'd1,
    ON_REMOVE  = 2'd2,
    ON_RESTORE = 2'd3
  } onCode_e;

  typedef struct packed {
    logic               visible;
    logic [7:0]         slot;
    logic [COORD_W-1:0] x;
    logic [COORD_W-1:0] y;
  } curState_t;

  typedef struct packed {
    logic memWe;
    logic isAlpha;
  } defStrobe_t;
endpackage

// File: rtl/cursor_blend_ch.sv
module cursor_blend_ch (
  input  logic [7:0] alpha,
  input  logic [7:0] fg,
  input  logic [7:0] bg,
  output logic [7:0] res
);
  logic [16:0] weighted;
  logic [16:0] rounded;

  always_comb begin
    weighted = 17'(alpha) * 17'(fg) + 17'(8'd255 - alpha) * 17'(bg);
    // divide by 255: x/255 == (x + 1 + x/256) / 256 for the 16-bit products here
    rounded  = weighted + 17'd1 + (weighted >> 8);
    res      = rounded[15:8];
  end
endmodule

// File: rtl/cursor_ctrl.sv
module cursor_ctrl
  import cursor_mix_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        capAlpha,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  input  logic [15:0] regWrData,
  input  logic        defWe,
  input  logic        defAlpha,
  output curState_t   curState,
  output defStrobe_t  defStrobe
);
  logic [7:0]         stagedId;
  logic [COORD_W-1:0] stagedX;
  logic [COORD_W-1:0] stagedY;
  logic               onLegal;

  assign onLegal = (regWrData[15:2] == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stagedId <= '0;
      stagedX  <= '0;
      stagedY  <= '0;
      curState <= '0;
    end else if (regWrEn) begin
      case (regSel_e'(regAddr))
        SEL_ID: stagedId <= regWrData[7:0];
        SEL_X:  stagedX  <= regWrData[COORD_W-1:0];
        SEL_Y:  stagedY  <= regWrData[COORD_W-1:0];
        SEL_ON: begin
          if (onLegal) begin
            case (onCode_e'(regWrData[1:0]))
              ON_HIDE: begin
                curState.slot    <= stagedId;
                curState.x       <= stagedX;
                curState.y       <= stagedY;
                curState.visible <= 1'b0;
              end
              ON_SHOW: begin
                curState.slot    <= stagedId;
                curState.x       <= stagedX;
                curState.y       <= stagedY;
                curState.visible <= 1'b1;
              end
              default: ; // no frame memory copy exists, nothing to remove or restore
            endcase
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    defStrobe.memWe   = defWe && (!defAlpha || capAlpha);
    defStrobe.isAlpha = defAlpha;
  end
endmodule

// File: rtl/cursor_datapath.sv
module cursor_datapath
  import cursor_mix_pkg::*;
#(
  parameter int NUM_SLOTS = 2,
  parameter int CUR_DIM   = 32,
  parameter int H_ACTIVE  = 640,
  parameter int V_ACTIVE  = 480,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int OFF_W    = $clog2(CUR_DIM),
  localparam int WADDR_W  = 2 * OFF_W
)(
  input  logic               clk,
  input  logic               rstN,
  input  curState_t          curState,
  input  defStrobe_t         defStrobe,
  input  logic [SLOT_W-1:0]  defSlot,
  input  logic [WADDR_W-1:0] defAddr,
  input  logic [WORD_W-1:0]  defWord,
  input  logic               pixValid,
  input  logic [COORD_W-1:0] pixX,
  input  logic [COORD_W-1:0] pixY,
  input  logic [PIX_W-1:0]   pixData,
  output logic               outValid,
  output logic [PIX_W-1:0]   outData
);
  localparam int MEM_WORDS = NUM_SLOTS * CUR_DIM * CUR_DIM;
  localparam int MADDR_W   = SLOT_W + WADDR_W;
  localparam logic [COORD_W:0]   DIM_L = (COORD_W+1)'(CUR_DIM);
  localparam logic [COORD_W-1:0] H_LIM = COORD_W'(H_ACTIVE);
  localparam logic [COORD_W-1:0] V_LIM = COORD_W'(V_ACTIVE);
  localparam int NUM_CH = PIX_W / 8;

  logic [WORD_W-1:0]    curMem [MEM_WORDS];
  logic [NUM_SLOTS-1:0] slotAlpha;

  // image load
  always_ff @(posedge clk) begin
    if (defStrobe.memWe) curMem[{defSlot, defAddr}] <= defWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) slotAlpha <= '0;
    else if (defStrobe.memWe) slotAlpha[defSlot] <= defStrobe.isAlpha;
  end

  // stage 0: coverage and address
  logic [COORD_W:0]   dx, dy;
  logic               hitX, hitY, inActive, hit;
  logic [MADDR_W-1:0] rdAddr;
  logic [SLOT_W-1:0]  curSlot;

  always_comb begin
    curSlot  = curState.slot[SLOT_W-1:0];
    dx       = {1'b0, pixX} - {1'b0, curState.x};
    dy       = {1'b0, pixY} - {1'b0, curState.y};
    hitX     = (pixX >= curState.x) && (dx < DIM_L);
    hitY     = (pixY >= curState.y) && (dy < DIM_L);
    inActive = (pixX < H_LIM) && (pixY < V_LIM);
    hit      = curState.visible && hitX && hitY && inActive;
    rdAddr   = {curSlot, dy[OFF_W-1:0], dx[OFF_W-1:0]};
  end

  // stage 1: registered pixel and cursor word
  logic              s1Valid, s1Hit, s1Alpha;
  logic [PIX_W-1:0]  s1Pix;
  logic [WORD_W-1:0] s1Word;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Hit   <= 1'b0;
      s1Alpha <= 1'b0;
      s1Pix   <= '0;
    end else begin
      s1Valid <= pixValid;
      s1Hit   <= hit;
      s1Alpha <= slotAlpha[curSlot];
      s1Pix   <= pixData;
    end
  end

  always_ff @(posedge clk) s1Word <= curMem[rdAddr];

  // stage 2: mix
  logic [PIX_W-1:0] blended, masked, mixed;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    cursor_blend_ch u_blend (
      .alpha (s1Word[WORD_W-1 -: 8]),
      .fg    (s1Word[ch*8 +: 8]),
      .bg    (s1Pix[ch*8 +: 8]),
      .res   (blended[ch*8 +: 8])
    );
  end

  always_comb begin
    masked = (s1Pix & {PIX_W{s1Word[0]}}) ^ {PIX_W{s1Word[1]}};
    if (!s1Hit)       mixed = s1Pix;
    else if (s1Alpha) mixed = blended;
    else              mixed = masked;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= s1Valid;
      if (s1Valid) outData <= mixed;
    end
  end
endmodule

// File: rtl/cursor_overlay_mixer.sv
module cursor_overlay_mixer
  import cursor_mix_pkg::*;
#(
  parameter int NUM_SLOTS = 2,
  parameter int CUR_DIM   = 32,
  parameter int H_ACTIVE  = 640,
  parameter int V_ACTIVE  = 480,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int WADDR_W  = 2 * $clog2(CUR_DIM)
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               capAlpha,
  input  logic               regWrEn,
  input  logic [1:0]         regAddr,
  input  logic [15:0]        regWrData,
  input  logic               defWe,
  input  logic               defAlpha,
  input  logic [SLOT_W-1:0]  defSlot,
  input  logic [WADDR_W-1:0] defAddr,
  input  logic [31:0]        defWord,
  input  logic               pixValid,
  input  logic [11:0]        pixX,
  input  logic [11:0]        pixY,
  input  logic [23:0]        pixData,
  output logic               outValid,
  output logic [23:0]        outData
);
  curState_t  curState;
  defStrobe_t defStrobe;

  cursor_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .capAlpha  (capAlpha),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .defWe     (defWe),
    .defAlpha  (defAlpha),
    .curState  (curState),
    .defStrobe (defStrobe)
  );

  cursor_datapath #(
    .NUM_SLOTS (NUM_SLOTS),
    .CUR_DIM   (CUR_DIM),
    .H_ACTIVE  (H_ACTIVE),
    .V_ACTIVE  (V_ACTIVE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .curState  (curState),
    .defStrobe (defStrobe),
    .defSlot   (defSlot),
    .defAddr   (defAddr),
    .defWord   (defWord),
    .pixValid  (pixValid),
    .pixX      (pixX),
    .pixY      (pixY),
    .pixData   (pixData),
    .outValid  (outValid),
    .outData   (outData)
  );
endmodule

// File: rtl/cursor_mix_checker.sv
module cursor_mix_checker
  import cursor_mix_pkg::*;
#(
  parameter int H_ACTIVE = 640,
  parameter int V_ACTIVE = 480
)(
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic [1:0]  regAddr,
  input logic [15:0] regWrData,
  input logic        pixValid,
  input logic [11:0] pixX,
  input logic [11:0] pixY,
  input logic [23:0] pixData,
  input logic        outValid,
  input logic [23:0] outData,
  input curState_t   curState
);
  logic [1:0] sinceRst;

  always_ff @(posedge clk) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  logic onWrite;
  assign onWrite = regWrEn && (regAddr == 2'd3);

  assert_latency_R9: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2) |-> (outValid == $past(pixValid, 2)));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd1 && !outValid) |-> $stable(outData));

  assert_blank_pass_R8: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2 && $past(pixValid, 2) &&
     (($past(pixX, 2) >= 12'(H_ACTIVE)) || ($past(pixY, 2) >= 12'(V_ACTIVE))))
    |-> (outData == $past(pixData, 2)));

  assert_noop_R4: assert property (@(posedge clk) disable iff (!rstN)
    (onWrite && (regWrData == 16'd2 || regWrData == 16'd3 || regWrData > 16'd3))
    |=> $stable(curState));

  assert_stage_only_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr != 2'd3) |=> $stable(curState));

  assert_show_R3: assert property (@(posedge clk) disable iff (!rstN)
    (onWrite && regWrData == 16'd1) |=> curState.visible);

  assert_hide_R3: assert property (@(posedge clk) disable iff (!rstN)
    (onWrite && regWrData == 16'd0) |=> !curState.visible);
endmodule

bind cursor_overlay_mixer cursor_mix_checker #(
  .H_ACTIVE (H_ACTIVE),
  .V_ACTIVE (V_ACTIVE)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .pixValid  (pixValid),
  .pixX      (pixX),
  .pixY      (pixY),
  .pixData   (pixData),
  .outValid  (outValid),
  .outData   (outData),
  .curState  (curState)
);

// File: tb/cursor_overlay_mixer_tb.sv
module cursor_overlay_mixer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        capAlpha = 1'b1;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic        defWe = 1'b0;
  logic        defAlpha = 1'b0;
  logic [0:0]  defSlot = '0;
  logic [9:0]  defAddr = '0;
  logic [31:0] defWord = '0;
  logic        pixValid = 1'b0;
  logic [11:0] pixX = '0;
  logic [11:0] pixY = '0;
  logic [23:0] pixData = '0;
  logic        outValid;
  logic [23:0] outData;

  always #2 clk = ~clk;

  cursor_overlay_mixer u_dut (
    .clk(clk), .rstN(rstN), .capAlpha(capAlpha),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .defWe(defWe), .defAlpha(defAlpha), .defSlot(defSlot),
    .defAddr(defAddr), .defWord(defWord),
    .pixValid(pixValid), .pixX(pixX), .pixY(pixY), .pixData(pixData),
    .outValid(outValid), .outData(outData)
  );

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 0;

  // bench model built from the requirements
  logic [31:0] mdlMem [2048];
  bit          mdlAlpha [2];
  int stId = 0, stX = 0, stY = 0;
  int acId = 0, acX = 0, acY = 0;
  bit vis = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] monoWord(int i);
    logic [9:0] b = 10'(i);
    return {30'b0, b[1] ^ b[6], b[0] ^ b[3]};
  endfunction

  function automatic logic [31:0] alphaWord(int i);
    if (i == 0) return 32'hFF123456;
    if (i == 1) return 32'h00ABCDEF;
    return {8'(i * 13), 8'(i * 7), 8'(i * 3 + 1), 8'(i)};
  endfunction

  function automatic logic [23:0] expPix(int x, int y, logic [23:0] p);
    logic [31:0] w;
    logic [23:0] r;
    int a;
    if (!vis || x >= 640 || y >= 480 || x < acX || x >= acX + 32 ||
        y < acY || y >= acY + 32) return p;
    w = mdlMem[acId * 1024 + (y - acY) * 32 + (x - acX)];
    if (mdlAlpha[acId]) begin
      a = int'(w[31:24]);
      for (int ch = 0; ch < 3; ch++)
        r[ch*8 +: 8] = 8'((a * int'(w[ch*8 +: 8]) + (255 - a) * int'(p[ch*8 +: 8])) / 255);
      return r;
    end
    return (p & {24{w[0]}}) ^ {24{w[1]}};
  endfunction

  task automatic regWrite(int addr, int data);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 2'(addr); regWrData = 16'(data);
    @(negedge clk);
    regWrEn = 1'b0;
    case (addr)
      0: stId = data & 1;
      1: stX = data & 12'hFFF;
      2: stY = data & 12'hFFF;
      default: begin
        if (data == 0 || data == 1) begin
          acId = stId; acX = stX; acY = stY; vis = (data == 1);
        end
      end
    endcase
  endtask

  task automatic defWrite(int slot, int addr, logic [31:0] word, bit alpha);
    @(negedge clk);
    defWe = 1'b1; defSlot = 1'(slot); defAddr = 10'(addr);
    defWord = word; defAlpha = alpha;
    @(negedge clk);
    defWe = 1'b0;
    if (!alpha || capAlpha) begin
      mdlMem[slot * 1024 + addr] = word;
      mdlAlpha[slot] = alpha;
    end
  endtask

  task automatic sendPixel(string req, int x, int y, logic [23:0] p);
    @(negedge clk);
    pixValid = 1'b1; pixX = 12'(x); pixY = 12'(y); pixData = p;
    @(negedge clk);
    pixValid = 1'b0;
    @(negedge clk);
    check({req, " valid"}, 32'(outValid), 32'd1);
    check(req, 32'(outData), 32'(expPix(x, y, p)));
  endtask

  task automatic testReset();
    check("R1 outValid", 32'(outValid), 32'd0);
    check("R1 outData", 32'(outData), 32'd0);
    sendPixel("R1 hidden", 0, 0, 24'h13579B);
  endtask

  task automatic loadImages();
    @(negedge clk);
    defWe = 1'b1;
    for (int i = 0; i < 2048; i++) begin
      defSlot = 1'(i / 1024); defAddr = 10'(i % 1024);
      defAlpha = (i >= 1024);
      defWord = (i >= 1024) ? alphaWord(i - 1024) : monoWord(i);
      mdlMem[i] = defWord;
      @(negedge clk);
    end
    defWe = 1'b0;
    mdlAlpha[0] = 0; mdlAlpha[1] = 1;
  endtask

  task automatic testStaging();
    regWrite(0, 0); regWrite(1, 100); regWrite(2, 50);
    sendPixel("R2 staged no effect", 100, 50, 24'hA5C3F0);
    check("R2 model hidden", 32'(vis), 32'd0);
  endtask

  task automatic testMono();
    regWrite(3, 1);
    sendPixel("R3 R5 corner 0", 100, 50, 24'hA5C3F0);
    sendPixel("R5 pos 1", 101, 50, 24'h00FF00);
    sendPixel("R5 pos 2", 102, 50, 24'h123456);
    sendPixel("R5 pos xor", 104, 51, 24'h0F0F0F);
    sendPixel("R5 far corner", 131, 81, 24'h55AA55);
    sendPixel("R8 right edge outside", 132, 50, 24'h777777);
    sendPixel("R8 left outside", 99, 50, 24'h777777);
    sendPixel("R8 below outside", 100, 82, 24'h777777);
  endtask

  task automatic testAlpha();
    regWrite(0, 1); regWrite(1, 200); regWrite(2, 100); regWrite(3, 1);
    sendPixel("R6 alpha 255", 200, 100, 24'hFFFFFF);
    sendPixel("R6 alpha 0", 201, 100, 24'h808080);
    sendPixel("R6 mid alpha a", 210, 105, 24'h204060);
    sendPixel("R6 mid alpha b", 231, 131, 24'hF0E0D0);
    sendPixel("R6 mid alpha c", 215, 120, 24'h00FF7F);
  endtask

  task automatic testNoop();
    regWrite(1, 300);
    regWrite(3, 2);
    sendPixel("R4 remove keeps old", 200, 100, 24'h010203);
    sendPixel("R4 remove no move", 300, 100, 24'h010203);
    regWrite(3, 3);
    sendPixel("R4 restore keeps old", 205, 101, 24'h445566);
    regWrite(3, 5);
    sendPixel("R4 bad code ignored", 300, 100, 24'h445566);
    sendPixel("R4 bad code still shown", 206, 102, 24'h445566);
  endtask

  task automatic testHide();
    regWrite(3, 0);
    sendPixel("R3 hide old spot", 205, 101, 24'h9ABCDE);
    sendPixel("R3 hide new spot", 305, 101, 24'h9ABCDE);
    check("R3 model hidden", 32'(vis), 32'd0);
  endtask

  task automatic testCapability();
    capAlpha = 1'b0;
    defWrite(0, 0, 32'hFFFFFFFF, 1'b1);
    regWrite(0, 0); regWrite(1, 100); regWrite(2, 50); regWrite(3, 1);
    sendPixel("R7 alpha define blocked word0", 100, 50, 24'hA5C3F0);
    sendPixel("R7 slot stays mono", 101, 50, 24'h3C3C3C);
    capAlpha = 1'b1;
    defWrite(0, 0, 32'h80FF0000, 1'b1);
    sendPixel("R7 alpha define accepted", 100, 50, 24'h0000FF);
    sendPixel("R7 slot kind now alpha", 101, 50, 24'h3C3C3C);
  endtask

  task automatic testClip();
    regWrite(0, 1); regWrite(1, 625); regWrite(2, 470); regWrite(3, 1);
    sendPixel("R8 inside near edge", 630, 475, 24'h102030);
    sendPixel("R8 last active", 639, 479, 24'h102030);
    sendPixel("R8 past width", 640, 475, 24'h102030);
    sendPixel("R8 past height", 630, 480, 24'h102030);
    regWrite(1, 4090); regWrite(2, 0); regWrite(3, 1);
    sendPixel("R8 no column wrap", 10, 0, 24'hCAFE01);
    regWrite(1, 0); regWrite(2, 4090); regWrite(3, 1);
    sendPixel("R8 no row wrap", 3, 10, 24'hCAFE02);
  endtask

  task automatic testTiming();
    logic [23:0] last;
    regWrite(1, 0); regWrite(2, 0); regWrite(3, 1);
    sendPixel("R9 setup", 40, 40, 24'h5A5A5A);
    last = outData;
    repeat (3) @(negedge clk);
    check("R9 idle valid low", 32'(outValid), 32'd0);
    check("R9 idle data held", 32'(outData), 32'(last));
    pixValid = 1'b1; pixX = 12'd2; pixY = 12'd2; pixData = 24'h111111;
    @(negedge clk);
    pixValid = 1'b0;
    check("R9 not yet valid", 32'(outValid), 32'd0);
    check("R9 data held one cycle", 32'(outData), 32'(last));
    @(negedge clk);
    check("R9 valid after two", 32'(outValid), 32'd1);
    check("R9 result", 32'(outData), 32'(expPix(2, 2, 24'h111111)));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    loadImages();
    testStaging();
    testMono();
    testAlpha();
    testNoop();
    testHide();
    testCapability();
    testClip();
    testTiming();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checkCount++;
      failCount++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checkCount, failCount);
      $finish;
    end
  end
endmodule